// File: doc/BRIEF.md
# Restoring Integer Divider with Right-Shifting Divisor

This block divides one unsigned integer by another over several clock cycles using the restoring method. A double-width remainder register is loaded with the dividend in its low half. A double-width divisor register is loaded with the divisor in its high half, and the quotient starts at zero. Each iteration does the following steps:

- It subtracts the divisor register from the remainder register over the full double width.
- It takes the sign of the difference from the extra top bit of the subtraction.
- On a negative difference it adds the divisor back, which restores the remainder.
- It shifts a new quotient bit into the bottom of the quotient. The bit is 1 for a non-negative difference and 0 for a negative one.
- It moves the divisor register one place to the right.

The block runs WIDTH+1 iterations, one per clock cycle. After the last one the low half of the remainder register holds the remainder.

A client places the operands on the inputs and raises `start` for one cycle while `busy` is low. The result appears together with a one-cycle `done` pulse. The result then stays on the outputs until the next accepted start. A zero divisor skips the iterations. It returns at once with an error flag, an all-ones quotient and the dividend as the remainder.

Top module: `divr_restoring`

## Requirements
- R1: During and right after reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: For a nonzero divisor, the result shown with `done` has `quotient` equal to floor(dividend/divisor) and `remainder` equal to dividend mod divisor. Together they satisfy dividend = quotient*divisor + remainder.
- R3: Suppose a start with a nonzero divisor is sampled at clock edge 0 while `busy` is low. Then `busy` is 1 after each of edges 0 through WIDTH and `done` is 0 during that time. After edge WIDTH+1, `done` is 1 and `busy` is 0.
- R4: For a nonzero divisor the remainder shown with `done` is strictly less than the divisor. The internal remainder never grows from one iteration to the next.
- R5: Suppose a start with divisor 0 is sampled at edge 0 while idle. Then after that same edge `done` and `div_by_zero` are both 1, `busy` is 0, `quotient` is all ones and `remainder` equals the dividend. `div_by_zero` is 0 whenever `done` follows a nonzero divisor.
- R6: A `start` pulse while `busy` is 1 is ignored. The running division completes at its original time with its original operands.
- R7: While `busy` is 0 and no start is sampled, `quotient` and `remainder` keep their values.
- R8: `done` lasts a single cycle. A start sampled in the cycle where `done` is high is accepted, because the block is idle then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with start |
| divisor | input | WIDTH | Unsigned divisor, sampled with start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| div_by_zero | output | 1 | High with done when the divisor was zero |
| quotient | output | WIDTH | Quotient of the last division |
| remainder | output | WIDTH | Remainder of the last division |

## Verification
The bench builds the divider with WIDTH=4 and the literal add-back restore. At that width every one of the 256 dividend and divisor pairs can be run, including all the zero-divisor cases. Every pair is compared against the arithmetic divide and modulo, and the cycle-by-cycle busy/done timing is checked each time. The reachable cases include the largest dividend with divisor 1 and dividends below the divisor. Directed runs add a start while busy and a back-to-back start in the done cycle.

// File: rtl/divr_pkg.sv
package divr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } divr_state_e;
endpackage

// File: rtl/divr_step.sv
// One restoring iteration: full-width subtract, sign test, restore, shifts.
module divr_step #(
    parameter int WIDTH       = 16,
    parameter bit RESTORE_ADD = 1'b1
) (
    input  logic [2*WIDTH-1:0] rem_i,
    input  logic [2*WIDTH-1:0] dvs_i,
    input  logic [WIDTH-1:0]   quo_i,
    output logic [2*WIDTH-1:0] rem_o,
    output logic [2*WIDTH-1:0] dvs_o,
    output logic [WIDTH-1:0]   quo_o,
    output logic               neg_o
);
    localparam int DW = 2 * WIDTH;

    logic [DW:0]   diff;
    logic [DW-1:0] diff_lo;

    // The extra top bit of the (DW+1)-bit difference carries the sign.
    assign diff    = {1'b0, rem_i} - {1'b0, dvs_i};
    assign diff_lo = diff[DW-1:0];
    assign neg_o   = diff[DW];

    generate
        if (RESTORE_ADD) begin : g_add_back
            // Restore by adding the divisor back onto the written difference.
            assign rem_o = neg_o ? (diff_lo + dvs_i) : diff_lo;
        end else begin : g_keep_old
            // Restore by selecting the unmodified remainder.
            assign rem_o = neg_o ? rem_i : diff_lo;
        end
    endgenerate

    assign quo_o = {quo_i[WIDTH-2:0], ~neg_o};
    assign dvs_o = {1'b0, dvs_i[DW-1:1]};
endmodule

// File: rtl/divr_seq.sv
// Iteration sequencer: idle/run state, iteration counter, done and error pulses.
module divr_seq
    import divr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dz_i,
    output logic load_o,
    output logic zero_o,
    output logic iter_o,
    output logic busy_o,
    output logic done_o,
    output logic dz_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH);

    typedef struct packed {
        divr_state_e   state;
        logic [CW-1:0] cnt;
        logic          done;
        logic          dz;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.dz   = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (dz_i) begin
                        seq_d.done = 1'b1;
                        seq_d.dz   = 1'b1;
                    end else begin
                        seq_d.state = ST_RUN;
                        seq_d.cnt   = '0;
                    end
                end
            end
            default: begin
                if (seq_q.cnt == LAST) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, done: 1'b0, dz: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign load_o = (seq_q.state == ST_IDLE) && start && !dz_i;
    assign zero_o = (seq_q.state == ST_IDLE) && start && dz_i;
    assign iter_o = (seq_q.state == ST_RUN);
    assign busy_o = (seq_q.state == ST_RUN);
    assign done_o = seq_q.done;
    assign dz_o   = seq_q.dz;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= LAST); // R3
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && seq_q.cnt != LAST) |=> (seq_q.state == ST_RUN && !seq_q.done)); // R3
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (seq_q.state == ST_IDLE)); // R8
    AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && seq_q.cnt != LAST && start) |=> (seq_q.cnt == $past(seq_q.cnt) + 1'b1)); // R6
endmodule

// File: rtl/divr_restoring.sv
// Top: operand/result registers around the sequencer and one iteration step.
module divr_restoring #(
    parameter int WIDTH       = 16,
    parameter bit RESTORE_ADD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_by_zero,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    localparam int DW = 2 * WIDTH;

    typedef struct packed {
        logic [DW-1:0]    rem;
        logic [DW-1:0]    dvs;
        logic [WIDTH-1:0] quo;
    } data_t;

    data_t data_d, data_q;

    logic             load, zero_start, iter, dz_in;
    logic [DW-1:0]    step_rem, step_dvs;
    logic [WIDTH-1:0] step_quo;
    logic             step_neg;

    assign dz_in = (divisor == '0);

    divr_seq #(.WIDTH(WIDTH)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .dz_i   (dz_in),
        .load_o (load),
        .zero_o (zero_start),
        .iter_o (iter),
        .busy_o (busy),
        .done_o (done),
        .dz_o   (div_by_zero)
    );

    divr_step #(.WIDTH(WIDTH), .RESTORE_ADD(RESTORE_ADD)) step_i (
        .rem_i (data_q.rem),
        .dvs_i (data_q.dvs),
        .quo_i (data_q.quo),
        .rem_o (step_rem),
        .dvs_o (step_dvs),
        .quo_o (step_quo),
        .neg_o (step_neg)
    );

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d.rem = {{WIDTH{1'b0}}, dividend};
            data_d.dvs = {divisor, {WIDTH{1'b0}}};
            data_d.quo = '0;
        end else if (zero_start) begin
            data_d.rem = {{WIDTH{1'b0}}, dividend};
            data_d.quo = '1;
        end else if (iter) begin
            data_d.rem = step_rem;
            data_d.dvs = step_dvs;
            data_d.quo = step_quo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign quotient  = data_q.quo;
    assign remainder = data_q.rem[WIDTH-1:0];

    AST_REM_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
        iter |=> (data_q.rem <= $past(data_q.rem))); // R4
    AST_REM_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (data_q.rem[DW-1:WIDTH] == '0)); // R2
    AST_ZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> (done && quotient == '1)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R8
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R3
endmodule

// File: tb/divr_restoring_tb_top.sv
`timescale 1ns/1ps
module divr_restoring_tb_top;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    divr_restoring #(.WIDTH(W), .RESTORE_ADD(1'b1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .div_by_zero (div_by_zero),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Start at the current negedge; optionally inject a start while busy
    // (R6) and optionally check hold for one idle cycle afterwards (R7, R8).
    task automatic run_div(input int a, input int b, input bit inject, input bit hold);
        int eq, er;
        start    = 1'b1;
        dividend = W'(a);
        divisor  = W'(b);
        @(negedge clk);
        start = 1'b0;
        if (b == 0) begin
            check(done == 1'b1, "R5 done", int'(done), 1);
            check(div_by_zero == 1'b1, "R5 flag", int'(div_by_zero), 1);
            check(busy == 1'b0, "R5 busy", int'(busy), 0);
            check(quotient == W'(MAXV), "R5 quotient", int'(quotient), MAXV);
            check(remainder == W'(a), "R5 remainder", int'(remainder), a);
        end else begin
            eq = a / b;
            er = a % b;
            check(busy == 1'b1 && done == 1'b0, "R3 busy after start", int'(busy), 1);
            for (int i = 1; i <= W; i++) begin
                if (inject && i == 1) begin
                    start    = 1'b1;
                    dividend = W'(MAXV - a);
                    divisor  = W'(1);
                end
                @(negedge clk);
                start = 1'b0;
                check(busy == 1'b1 && done == 1'b0, inject ? "R6 still busy" : "R3 busy window",
                      int'({busy, done}), 2);
            end
            @(negedge clk);
            check(done == 1'b1 && busy == 1'b0, "R3 done timing", int'({busy, done}), 1);
            check(div_by_zero == 1'b0, "R5 no flag", int'(div_by_zero), 0);
            check(quotient == W'(eq), inject ? "R6 quotient" : "R2 quotient", int'(quotient), eq);
            check(remainder == W'(er), inject ? "R6 remainder" : "R2 remainder", int'(remainder), er);
            check(int'(remainder) < b, "R4 remainder below divisor", int'(remainder), b - 1);
        end
        if (hold) begin
            eq = int'(quotient);
            er = int'(remainder);
            @(negedge clk);
            check(done == 1'b0, "R8 single pulse", int'(done), 0);
            check(div_by_zero == 1'b0, "R8 flag clears", int'(div_by_zero), 0);
            @(negedge clk);
            check(int'(quotient) == eq, "R7 quotient held", int'(quotient), eq);
            check(int'(remainder) == er, "R7 remainder held", int'(remainder), er);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && div_by_zero == 1'b0, "R1 flags in reset",
              int'({busy, done, div_by_zero}), 0);
        check(quotient == '0 && remainder == '0, "R1 results in reset",
              int'({quotient, remainder}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);
        check(quotient == '0 && remainder == '0, "R1 results after reset",
              int'({quotient, remainder}), 0);

        // Directed: the seven-by-two case.
        run_div(7, 2, 1'b0, 1'b1);

        // Exhaustive sweep over every operand pair.
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                run_div(a, b, 1'b0, 1'b1);
            end
        end

        // Start pulses while busy are ignored.
        run_div(13, 3, 1'b1, 1'b1);
        run_div(MAXV, 1, 1'b1, 1'b1);

        // Back-to-back: start in the done cycle.
        run_div(11, 4, 1'b0, 1'b0);
        run_div(9, 2, 1'b0, 1'b0);
        run_div(5, 0, 1'b0, 1'b0);
        check(done == 1'b1, "R8 zero start after done", int'(done), 1);
        run_div(14, 5, 1'b0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule